// File: doc/BRIEF.md
# Accumulator Status-Flag ALU

This block is the arithmetic and logic unit of an 8-bit accumulator processor. A decoder supplies a 4-bit operation code, the accumulator (A), the two index registers (X and Y), one operand byte and the current status byte. One clock after the request, the block returns a result byte, a code that says where that result belongs, and the updated status byte. A result-valid strobe marks the cycle that carries a new result. Each operation changes only its own set of flags. Every other status bit passes through unchanged.

The operations are add with carry, subtract with borrow, compare against A, X or Y, the bit test, AND, OR and XOR, increment and decrement, left and right shifts and rotates through carry, and an AND-then-subtract that writes X. Decimal arithmetic, register storage, instruction decode and memory access belong to the surrounding core. For a shift of the accumulator, the core presents A as the operand and routes the result back to A.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) forms A + operand + C in 9 bits. The result is the low byte and C is bit 8. V is set when A and the operand share a sign and the result's sign differs from A. The destination is A (code 0).
- R2: Op 1 (subtract) forms A − operand − (1 − C). C is set when no borrow occurs. V is set when A and the operand differ in sign and the result's sign differs from A. The destination is A (code 0).
- R3: Ops 2, 3 and 4 compare A, X and Y respectively against the operand. The result is the 8-bit difference and the destination is none (code 2). C is set when the register is greater than or equal to the operand. V is unchanged.
- R4: Op 5 (bit test) returns A AND operand with destination none (code 2). Z is set when that value is zero. N takes operand bit 7 and V takes operand bit 6. C is unchanged.
- R5: Ops 6, 7 and 8 return A AND, OR and XOR the operand respectively, with destination A (code 0). Only Z and N change.
- R6: Ops 9 and 10 return the operand plus one and minus one, modulo 256, with destination operand (code 3). Only Z and N change.
- R7: Op 11 shifts the operand left: bit 7 goes to C and bit 0 becomes zero. Op 12 shifts it right: bit 0 goes to C, bit 7 becomes zero and N is therefore cleared. The destination is operand (code 3).
- R8: Op 13 rotates the operand left through carry: the old C enters bit 0 and bit 7 goes to C. Op 14 rotates it right through carry: the old C enters bit 7 and bit 0 goes to C. The destination is operand (code 3).
- R9: Op 15 returns (A AND X) − operand with destination X (code 1). It sets C, Z and N as a compare does, and V is unchanged.
- R10: The status layout is C bit 0, Z bit 1, interrupt mask bit 2, decimal bit 3, break bit 4, spare bit 5, V bit 6, N bit 7. Bits 2 to 5 always pass through unchanged. Z is set exactly when the result byte is zero. For every op other than the bit test, N equals result bit 7.
- R11: The outputs update on the clock edge that samples a request (in_valid high), and out_valid is high for exactly that following cycle. Without a request, result, dest and status_out hold their values and out_valid is low.
- R12: While reset is asserted, and until the synchronised release, out_valid, result, dest and status_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; samples the operation inputs |
| op | input | 4 | Operation code (0 to 15, see requirements) |
| acc | input | 8 | Accumulator A |
| xreg | input | 8 | Index register X |
| yreg | input | 8 | Index register Y |
| operand | input | 8 | Operand byte |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| result | output | 8 | Result byte |
| dest | output | 2 | 0 = A, 1 = X, 2 = none, 3 = operand location |
| status_out | output | 8 | Updated status byte |

## Verification
Every faulty internal choice in this block shows up at the ports in the single cycle after the request. That cycle is the only one in which the result, dest and status_out reflect the inputs, so the bench compares all three on every request. A wrong operand select, carry injection or overflow term corrupts result, C or V only for particular sign and carry combinations. For that reason the sweep crosses sign-boundary bytes (0x00, 0x01, 0x7F, 0x80, 0xFE, 0xFF) with both carry states for every operation. A broken clock enable shows up the first cycle after a request ends, as held outputs that change or a strobe that stays high.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW     = 8;
  localparam int OPW    = 4;
  localparam int DSTW   = 2;

  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_V   = 6;
  localparam int FL_N   = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMPA = 4'd2,
    OP_CMPX = 4'd3,
    OP_CMPY = 4'd4,
    OP_BIT  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SHL  = 4'd11,
    OP_SHR  = 4'd12,
    OP_RTL  = 4'd13,
    OP_RTR  = 4'd14,
    OP_AXS  = 4'd15
  } alu_op_e;

  typedef enum logic [DSTW-1:0] {
    DST_A    = 2'd0,
    DST_X    = 2'd1,
    DST_NONE = 2'd2,
    DST_OPND = 2'd3
  } alu_dst_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  xreg,
  input  logic [DW-1:0]  yreg,
  input  logic [DW-1:0]  operand,
  input  logic           cin,
  output logic [DW-1:0]  sum,
  output logic           cout,
  output logic           vout
);
  logic [DW-1:0] lhs;
  logic [DW-1:0] rhs;
  logic          c0;
  logic [DW:0]   wide;

  // left operand select: compares pick their register, the combined op masks A with X
  always_comb begin
    unique case (op)
      OP_CMPX: lhs = xreg;
      OP_CMPY: lhs = yreg;
      OP_AXS:  lhs = acc & xreg;
      default: lhs = acc;
    endcase
  end

  // subtraction is addition of the complement; carry-in is the inverted borrow
  assign rhs  = (op == OP_ADD) ? operand : ~operand;
  assign c0   = (op == OP_ADD || op == OP_SUB) ? cin : 1'b1;
  assign wide = {1'b0, lhs} + {1'b0, rhs} + {{DW{1'b0}}, c0};
  assign sum  = wide[DW-1:0];
  assign cout = wide[DW];
  assign vout = (lhs[DW-1] == rhs[DW-1]) && (sum[DW-1] != lhs[DW-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  operand,
  output logic [DW-1:0]  res
);
  always_comb begin
    unique case (op)
      OP_OR:   res = acc | operand;
      OP_XOR:  res = acc ^ operand;
      OP_INC:  res = operand + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:  res = operand - {{(DW-1){1'b0}}, 1'b1};
      default: res = acc & operand;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  operand,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cout
);
  logic fill;

  // rotates feed the old carry in; plain shifts feed zero
  assign fill = (op == OP_RTL || op == OP_RTR) ? cin : 1'b0;

  always_comb begin
    if (op == OP_SHR || op == OP_RTR) begin
      res  = {fill, operand[DW-1:1]};
      cout = operand[0];
    end else begin
      res  = {operand[DW-2:0], fill};
      cout = operand[DW-1];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPW-1:0]    op,
  input  logic [DW-1:0]     acc,
  input  logic [DW-1:0]     xreg,
  input  logic [DW-1:0]     yreg,
  input  logic [DW-1:0]     operand,
  input  logic [DW-1:0]     status_in,
  output logic              out_valid,
  output logic [DW-1:0]     result,
  output logic [DSTW-1:0]   dest,
  output logic [DW-1:0]     status_out
);
  alu_op_e       op_e;
  logic [1:0]    rst_sync;
  logic          rst_int_n;

  logic [DW-1:0] as_sum, lg_res, sh_res;
  logic          as_c, as_v, sh_c;

  logic [DW-1:0] res_nx, st_nx;
  alu_dst_e      dst_nx;

  logic [DW-1:0] res_q, st_q;
  logic [DSTW-1:0] dst_q;
  logic          vld_q;

  assign op_e = alu_op_e'(op);

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  alu8_addsub u_addsub (
    .op(op_e), .acc(acc), .xreg(xreg), .yreg(yreg), .operand(operand),
    .cin(status_in[FL_C]), .sum(as_sum), .cout(as_c), .vout(as_v)
  );

  alu8_logic u_logic (
    .op(op_e), .acc(acc), .operand(operand), .res(lg_res)
  );

  alu8_shift u_shift (
    .op(op_e), .operand(operand), .cin(status_in[FL_C]),
    .res(sh_res), .cout(sh_c)
  );

  // next-state: pick result, destination and per-op flag updates
  always_comb begin
    st_nx  = status_in;
    res_nx = lg_res;
    dst_nx = DST_A;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        res_nx       = as_sum;
        st_nx[FL_C]  = as_c;
        st_nx[FL_V]  = as_v;
      end
      OP_CMPA, OP_CMPX, OP_CMPY: begin
        res_nx       = as_sum;
        dst_nx       = DST_NONE;
        st_nx[FL_C]  = as_c;
      end
      OP_AXS: begin
        res_nx       = as_sum;
        dst_nx       = DST_X;
        st_nx[FL_C]  = as_c;
      end
      OP_BIT: begin
        dst_nx       = DST_NONE;
        st_nx[FL_V]  = operand[DW-2];
      end
      OP_INC, OP_DEC: begin
        dst_nx       = DST_OPND;
      end
      OP_SHL, OP_SHR, OP_RTL, OP_RTR: begin
        res_nx       = sh_res;
        dst_nx       = DST_OPND;
        st_nx[FL_C]  = sh_c;
      end
      default: begin
        dst_nx       = DST_A;
      end
    endcase
    st_nx[FL_Z] = (res_nx == '0);
    st_nx[FL_N] = (op_e == OP_BIT) ? operand[DW-1] : res_nx[DW-1];
  end

  // registers with explicit load enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      dst_q <= '0;
      st_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_nx;
        dst_q <= dst_nx;
        st_q  <= st_nx;
      end
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign dest       = dst_q;
  assign status_out = st_q;
endmodule

// File: rtl/alu8_check.sv
module alu8_check
  import alu8_pkg::*;
(
  input logic            clk,
  input logic            rst_int_n,
  input logic            in_valid,
  input logic [OPW-1:0]  op,
  input logic [DW-1:0]   operand,
  input logic [DW-1:0]   status_in,
  input logic            out_valid,
  input logic [DW-1:0]   result,
  input logic [DSTW-1:0] dest,
  input logic [DW-1:0]   status_out
);
  // R11: strobe follows a request by one cycle
  assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(status_out) && $stable(dest)));

  // R10: control bits pass straight through
  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> status_out[5:2] == $past(status_in[5:2]));
  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> status_out[FL_Z] == (result == '0));

  // R5 / R6: logical and step ops leave C and V
  assert_keep_cv_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_INC || op == OP_DEC))
    |=> (status_out[FL_C] == $past(status_in[FL_C]) && status_out[FL_V] == $past(status_in[FL_V])));

  // R3: compares store nothing and keep V
  assert_cmp_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op == OP_CMPA || op == OP_CMPX || op == OP_CMPY))
    |=> (dest == DST_NONE && status_out[FL_V] == $past(status_in[FL_V])));

  // R4: bit test copies operand bits to N and V
  assert_bit_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == OP_BIT)
    |=> (status_out[FL_N] == $past(operand[7]) && status_out[FL_V] == $past(operand[6])));

  // R7: logical right shift always clears N
  assert_shr_n_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == OP_SHR) |=> !status_out[FL_N]);
endmodule

bind alu8_core alu8_check u_check (
  .clk(clk), .rst_int_n(rst_int_n), .in_valid(in_valid), .op(op),
  .operand(operand), .status_in(status_in), .out_valid(out_valid),
  .result(result), .dest(dest), .status_out(status_out)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] op;
  logic [7:0] acc, xreg, yreg, operand, status_in;
  logic       out_valid;
  logic [7:0] result;
  logic [1:0] dest;
  logic [7:0] status_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
    .xreg(xreg), .yreg(yreg), .operand(operand), .status_in(status_in),
    .out_valid(out_valid), .result(result), .dest(dest), .status_out(status_out)
  );

  function automatic string tag(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6, 7, 8: return "R5";
      9, 10: return "R6";
      11, 12: return "R7";
      13, 14: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] sweep_val(input int k);
    case (k)
      16: return 8'h7F;
      17: return 8'h80;
      18: return 8'h01;
      19: return 8'hFE;
      default: return 8'(k * 17);
    endcase
  endfunction

  // reference model: returns {dest, result, status}
  function automatic logic [17:0] model(input int o, input logic [7:0] a, x, y, b, p);
    int          ua, ub, uc, sa, sb, sr, t;
    logic [7:0]  r, s;
    logic [1:0]  d;
    bit          bitop;
    s = p; uc = int'(p[0]); ua = int'(a); ub = int'(b); bitop = 0; d = 2'd0; r = 8'h00;
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    case (o)
      0: begin t = ua + ub + uc; r = 8'(t); s[0] = (t > 255);
               sr = sa + sb + uc; s[6] = (sr > 127 || sr < -128); d = 2'd0; end
      1: begin t = ua - ub - (1 - uc); r = 8'(t); s[0] = (t >= 0);
               sr = sa - sb - (1 - uc); s[6] = (sr > 127 || sr < -128); d = 2'd0; end
      2, 3, 4, 15: begin
               if (o == 2) t = ua; else if (o == 3) t = int'(x);
               else if (o == 4) t = int'(y); else t = int'(a & x);
               s[0] = (t >= ub); r = 8'(t - ub); d = (o == 15) ? 2'd1 : 2'd2; end
      5: begin r = a & b; s[7] = b[7]; s[6] = b[6]; d = 2'd2; bitop = 1; end
      6: begin r = a & b; d = 2'd0; end
      7: begin r = a | b; d = 2'd0; end
      8: begin r = a ^ b; d = 2'd0; end
      9: begin r = 8'((ub + 1) % 256); d = 2'd3; end
      10: begin r = 8'((ub + 255) % 256); d = 2'd3; end
      11: begin r = 8'((ub * 2) % 256); s[0] = (ub >= 128); d = 2'd3; end
      12: begin r = 8'(ub / 2); s[0] = (ub % 2 == 1); d = 2'd3; end
      13: begin r = 8'((ub * 2 + uc) % 256); s[0] = (ub >= 128); d = 2'd3; end
      default: begin r = 8'(ub / 2 + uc * 128); s[0] = (ub % 2 == 1); d = 2'd3; end
    endcase
    s[1] = (r == 8'h00);
    if (!bitop) s[7] = (r >= 8'h80);
    return {d, r, s};
  endfunction

  task automatic apply(input int o, input logic [7:0] a, x, y, b, p);
    logic [17:0] exp;
    exp = model(o, a, x, y, b, p);
    in_valid = 1'b1; op = 4'(o); acc = a; xreg = x; yreg = y; operand = b; status_in = p;
    @(negedge clk);
    total++;
    if (!out_valid || {dest, result, status_out} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%h x=%h y=%h b=%h p=%h: got v=%b d=%0d r=%h s=%h exp d=%0d r=%h s=%h",
               tag(o), o, a, x, y, b, p, out_valid, dest, result, status_out,
               exp[17:16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; acc = '0; xreg = '0; yreg = '0;
    operand = '0; status_in = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    total++;
    if (out_valid || result !== 8'h00 || dest !== 2'd0 || status_out !== 8'h00) begin
      bad++;
      $display("FAIL R12 reset: got v=%b r=%h d=%0d s=%h exp all zero", out_valid, result, dest, status_out);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // binary ops: sign-boundary sweep with both carry states (R1..R5, R9, R10)
    for (int o = 0; o < 16; o++) begin
      if (o == 0 || o == 1 || (o >= 2 && o <= 8) || o == 15) begin
        for (int i = 0; i < 20; i++)
          for (int j = 0; j < 20; j++)
            for (int c = 0; c < 2; c++)
              apply(o, sweep_val(i), sweep_val((i + j + 3) % 20), sweep_val((j + 7) % 20),
                    sweep_val(j), (sweep_val(i) ^ 8'h5A) & 8'hFE | 8'(c));
      end
    end

    // unary ops: every operand byte, both carries (R6, R7, R8, R10)
    for (int o = 9; o <= 14; o++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          apply(o, 8'(b * 7), 8'h33, 8'hCC, 8'(b), (8'(b) ^ 8'hA5) & 8'hFE | 8'(c));

    // R11: outputs hold without a request
    apply(0, 8'h7F, 8'h00, 8'h00, 8'h01, 8'h00);
    in_valid = 1'b0; op = 4'd6; acc = 8'hFF; operand = 8'h0F; status_in = 8'hFF;
    @(negedge clk);
    total++;
    if (out_valid || result !== 8'h80 || dest !== 2'd0 || status_out !== 8'hC0) begin
      bad++;
      $display("FAIL R11 hold: got v=%b r=%h d=%0d s=%h exp v=0 r=80 d=0 s=c0",
               out_valid, result, dest, status_out);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule